// File: doc/BRIEF.md
# Periodic Interval-Timer Scan Trigger

This block starts a queue of conversion command words at a fixed, programmable rate. The system clock is divided down into a conversion-clock enable. An interval counter counts those enables and raises a one-cycle trigger each time the selected interval runs out.

Each trigger either starts the queue from its first word or resumes a queue that is waiting after a pause word. The queue then walks forward on its own, one word at a time. For each word it issues a start strobe and a channel number to the converter, and it returns the converter's result with the index of the word. A run ends at an end-of-queue word or at the end of the table.

Three flags record the following events: the queue finishing, the queue pausing, and a trigger arriving while the queue is still busy. Each flag stays set until it is cleared. The completion flag can raise an interrupt, which tells software that a new set of periodic samples is ready.

Top module: `interval_scan_trigger`

## Requirements
- R1: While enabled, `interval_tick` pulses for one cycle every 2·(P+1)·2^(7+n) system clocks, where P is `psc_sel` and n is `ivl_sel`.
- R2: The counters sit at zero while the timer is disabled. After `ivl_sel` takes a valid code, the first tick comes one full interval later: the cycle after the (interval−1)-th rising edge that sees the valid code.
- R3: An `ivl_sel` code from 11 to 15 disables the timer. No tick occurs and no queue activity starts.
- R4: A tick while the queue is idle starts execution at word 0. Words are executed in ascending index order, one at a time. `conv_start` pulses for one cycle with `conv_chan` equal to the word's bits [3:0].
- R5: A word with bit 4 set (pause) is converted first, then the queue suspends and `pause_flag` is set. The next tick resumes execution at the following word.
- R6: A word with bit 5 set (end-of-queue) ends the run without a conversion. Reaching index 8 (past the table) also ends the run. Either way `cmp_flag` is set, and the next tick restarts execution at word 0.
- R7: A tick that arrives while the queue is issuing or waiting on a conversion sets `ovr_flag`. A tick that arrives while the queue is idle or paused does not.
- R8: `cmp_flag` (clear bit 0), `pause_flag` (clear bit 1) and `ovr_flag` (clear bit 2) are zero after reset. Each stays set until a one on its bit of `flag_clr`. If a set and a clear happen in the same cycle, the set wins.
- R9: `cmp_irq` is high exactly when `cmp_flag` and `irq_en` are both high.
- R10: One cycle after `conv_done`, `res_valid` pulses with `res_idx` equal to the word index and `res_data` equal to `conv_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc_sel | input | 4 | Prescaler field P; divide by 2·(P+1) |
| ivl_sel | input | 4 | Interval code n: 2^(7+n) conversion-clock periods; codes 11 to 15 disable the timer |
| queue_words | input | 48 | Eight 6-bit command words, word i at bits [6i+5:6i] |
| irq_en | input | 1 | Completion interrupt enable |
| flag_clr | input | 3 | Write-one-to-clear for completion, pause and overrun flags |
| conv_done | input | 1 | Converter finished the current conversion |
| conv_data | input | 10 | Converter result |
| interval_tick | output | 1 | Timer trigger pulse |
| conv_start | output | 1 | Converter start strobe |
| conv_chan | output | 4 | Channel of the current word |
| res_valid | output | 1 | Result strobe |
| res_idx | output | 4 | Index of the word that produced the result |
| res_data | output | 10 | Result value |
| cmp_flag | output | 1 | Sticky queue-complete flag |
| pause_flag | output | 1 | Sticky queue-paused flag |
| ovr_flag | output | 1 | Sticky trigger-overrun flag |
| cmp_irq | output | 1 | Completion interrupt |

## Verification
The tick period is measured for every combination of three prescaler values and three interval codes. This separates an error in the divider from an error in the interval counter, and it also checks the latency from enabling the timer to the first tick. Every disabling code is applied to confirm that the timer stays silent. A pause word is placed at each of the eight positions in turn, and separately an end-of-queue word is placed at each of the eight positions. Each of these checks how many results come before and after a resume, and at which index a restart begins. A queue with no terminator checks that the table end finishes a run. A slow converter model forces ticks to land mid-conversion, which separates a busy-queue overrun from the harmless ticks that reach an idle or paused queue.

// File: rtl/interval_scan_trigger.sv
module interval_scan_trigger #(
  parameter int PSC_W  = 4,
  parameter int QDEPTH = 8,
  parameter int CH_W   = 4,
  parameter int RES_W  = 10,
  parameter int EXP_MIN = 7,
  parameter int NCODES = 11,
  localparam int WORD_W = CH_W + 2,
  localparam int IDX_W  = $clog2(QDEPTH + 1),
  localparam int ICNT_W = EXP_MIN + NCODES - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PSC_W-1:0]         psc_sel,
  input  logic [3:0]               ivl_sel,
  input  logic [QDEPTH*WORD_W-1:0] queue_words,
  input  logic                     irq_en,
  input  logic [2:0]               flag_clr,
  input  logic                     conv_done,
  input  logic [RES_W-1:0]         conv_data,
  output logic                     interval_tick,
  output logic                     conv_start,
  output logic [CH_W-1:0]          conv_chan,
  output logic                     res_valid,
  output logic [IDX_W-1:0]         res_idx,
  output logic [RES_W-1:0]         res_data,
  output logic                     cmp_flag,
  output logic                     pause_flag,
  output logic                     ovr_flag,
  output logic                     cmp_irq
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_PAUSE} seq_t;

  logic [PSC_W:0]     psc_cnt;
  logic [ICNT_W-1:0]  ivl_cnt;
  logic [ICNT_W-1:0]  ivl_last;
  logic               tmr_en, qtick;
  seq_t               state;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   idx_safe;
  logic [WORD_W-1:0]  cur_word;
  logic               at_end, stop;
  logic               cmp_set, pause_set, ovr_set;

  assign tmr_en   = ivl_sel < 4'(NCODES);
  assign qtick    = tmr_en && (psc_cnt >= {psc_sel, 1'b1});
  assign ivl_last = (ICNT_W'(1) << (5'(ivl_sel) + 5'(EXP_MIN))) - ICNT_W'(1);
  assign interval_tick = qtick && (ivl_cnt >= ivl_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_cnt <= '0;
      ivl_cnt <= '0;
    end else if (!tmr_en) begin
      psc_cnt <= '0;
      ivl_cnt <= '0;
    end else begin
      psc_cnt <= qtick ? '0 : psc_cnt + 1'b1;
      if (qtick) ivl_cnt <= interval_tick ? '0 : ivl_cnt + 1'b1;
    end
  end

  assign at_end   = idx >= IDX_W'(QDEPTH);
  assign idx_safe = at_end ? '0 : idx;
  assign cur_word = queue_words[32'(idx_safe)*WORD_W +: WORD_W];
  assign stop     = at_end || cur_word[CH_W+1];

  assign conv_start = (state == S_ISSUE) && !stop;
  assign conv_chan  = cur_word[CH_W-1:0];

  assign cmp_set   = (state == S_ISSUE) && stop;
  assign pause_set = (state == S_WAIT) && conv_done && cur_word[CH_W];
  assign ovr_set   = interval_tick && (state == S_ISSUE || state == S_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      res_valid <= 1'b0;
      res_idx   <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        S_IDLE:
          if (interval_tick) begin
            idx   <= '0;
            state <= S_ISSUE;
          end
        S_ISSUE:
          state <= stop ? S_IDLE : S_WAIT;
        S_WAIT:
          if (conv_done) begin
            res_valid <= 1'b1;
            res_idx   <= idx;
            res_data  <= conv_data;
            idx       <= idx + 1'b1;
            state     <= cur_word[CH_W] ? S_PAUSE : S_ISSUE;
          end
        S_PAUSE:
          if (interval_tick) state <= S_ISSUE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_flag   <= 1'b0;
      pause_flag <= 1'b0;
      ovr_flag   <= 1'b0;
    end else begin
      cmp_flag   <= cmp_set   | (cmp_flag   & ~flag_clr[0]);
      pause_flag <= pause_set | (pause_flag & ~flag_clr[1]);
      ovr_flag   <= ovr_set   | (ovr_flag   & ~flag_clr[2]);
    end
  end

  assign cmp_irq = cmp_flag & irq_en;

endmodule

// File: rtl/interval_scan_trigger_chk.sv
module interval_scan_trigger_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ivl_sel,
  input logic [2:0] flag_clr,
  input logic       conv_done,
  input logic       interval_tick,
  input logic       conv_start,
  input logic       res_valid,
  input logic       cmp_flag,
  input logic       pause_flag,
  input logic       ovr_flag
);

  // R3
  disabled_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    interval_tick |-> ivl_sel < 4'd11);

  // R4
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R5
  pause_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_flag) |-> $past(conv_done));

  // R6
  cmp_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> !$past(conv_start));

  // R7
  ovr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(interval_tick));

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_flag) |-> $past(flag_clr[2]));

  // R8
  cmp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmp_flag) |-> $past(flag_clr[0]));

  // R10
  result_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(conv_done));

endmodule

bind interval_scan_trigger interval_scan_trigger_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ivl_sel(ivl_sel), .flag_clr(flag_clr),
  .conv_done(conv_done), .interval_tick(interval_tick), .conv_start(conv_start),
  .res_valid(res_valid), .cmp_flag(cmp_flag), .pause_flag(pause_flag),
  .ovr_flag(ovr_flag)
);

// File: tb/tb_interval_scan_trigger.sv
module tb_interval_scan_trigger;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  psc_sel = '0;
  logic [3:0]  ivl_sel = 4'd15;
  logic [47:0] queue_words = '0;
  logic        irq_en = 1'b0;
  logic [2:0]  flag_clr = '0;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_data = '0;
  logic        interval_tick, conv_start, res_valid;
  logic [3:0]  conv_chan, res_idx;
  logic [9:0]  res_data;
  logic        cmp_flag, pause_flag, ovr_flag, cmp_irq;

  interval_scan_trigger dut (
    .clk(clk), .rst_n(rst_n), .psc_sel(psc_sel), .ivl_sel(ivl_sel),
    .queue_words(queue_words), .irq_en(irq_en), .flag_clr(flag_clr),
    .conv_done(conv_done), .conv_data(conv_data), .interval_tick(interval_tick),
    .conv_start(conv_start), .conv_chan(conv_chan), .res_valid(res_valid),
    .res_idx(res_idx), .res_data(res_data), .cmp_flag(cmp_flag),
    .pause_flag(pause_flag), .ovr_flag(ovr_flag), .cmp_irq(cmp_irq)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int lat = 3;
  int ccnt = 0;
  logic busy = 1'b0;
  logic [3:0] cch = '0;
  int rec_idx[64];
  int nrec = 0;
  bit done_flag = 0;

  function automatic logic [9:0] model(input logic [3:0] ch);
    return 10'(ch * 37 + 5);
  endfunction

  function automatic logic [5:0] word(input int ch, input bit p, input bit e);
    return {e, p, 4'(ch)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) begin
      busy <= 1'b1;
      ccnt <= lat;
      cch  <= conv_chan;
    end else if (busy) begin
      if (ccnt <= 1) begin
        busy      <= 1'b0;
        conv_done <= 1'b1;
        conv_data <= model(cch);
      end else ccnt <= ccnt - 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (nrec < 64) rec_idx[nrec] = int'(res_idx);
      nrec++;
      // R10: data equals converter output for the word's channel
      chk(res_data == model(queue_words[res_idx*6 +: 4]), "R10",
          int'(res_data), int'(model(queue_words[res_idx*6 +: 4])));
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    ivl_sel = 4'd15;
    flag_clr = '0;
    lat = 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_tick_then(input int n);
    do @(negedge clk); while (!interval_tick);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_run(input int start, input int cnt, input string req);
    chk(nrec == cnt, req, nrec, cnt);
    for (int i = 0; i < cnt && i < nrec; i++)
      chk(rec_idx[i] == start + i, req, rec_idx[i], start + i);
    nrec = 0;
  endtask

  task automatic pulse_clr(input logic [2:0] c);
    flag_clr = c;
    @(negedge clk);
    flag_clr = '0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R8: reset state
    chk(cmp_flag == 0 && pause_flag == 0 && ovr_flag == 0, "R8", int'({cmp_flag, pause_flag, ovr_flag}), 0);
    chk(conv_start == 0 && res_valid == 0 && cmp_irq == 0, "R9", int'({conv_start, res_valid, cmp_irq}), 0);

    // R1 / R2: period sweep
    queue_words = {8{word(0, 0, 1)}};
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 3; c++) begin
        int per, cnt;
        do_reset();
        per = 2 * (p + 1) * (128 << c);
        psc_sel = 4'(p);
        ivl_sel = 4'(c);
        cnt = 0;
        do begin @(posedge clk); cnt++; @(negedge clk); end while (!interval_tick && cnt < 5000);
        chk(cnt == per - 1, "R2", cnt, per - 1);
        cnt = 0;
        do begin @(posedge clk); cnt++; @(negedge clk); end while (!interval_tick && cnt < 5000);
        chk(cnt == per, "R1", cnt, per);
      end
    end

    // R3: disabling codes
    for (int c = 11; c < 16; c++) begin
      int seen;
      do_reset();
      queue_words = {8{word(2, 0, 0)}};
      psc_sel = 0;
      ivl_sel = 4'(c);
      nrec = 0;
      seen = 0;
      repeat (600) begin @(negedge clk); if (interval_tick || conv_start) seen++; end
      chk(seen == 0 && nrec == 0, "R3", seen + nrec, 0);
    end

    // R4 R5 R6 R7 R9: pause at 2, end-of-queue at 5
    do_reset();
    for (int i = 0; i < 8; i++) queue_words[i*6 +: 6] = word(i + 3, i == 2, i == 5);
    irq_en = 1'b1;
    psc_sel = 0;
    ivl_sel = 0;
    nrec = 0;
    wait_tick_then(100);
    chk_run(0, 3, "R4");
    chk(pause_flag == 1 && cmp_flag == 0, "R5", int'({pause_flag, cmp_flag}), 2);
    wait_tick_then(100);
    chk_run(3, 2, "R5");
    chk(cmp_flag == 1, "R6", cmp_flag, 1);
    chk(cmp_irq == 1, "R9", cmp_irq, 1);
    wait_tick_then(100);
    chk_run(0, 3, "R6");
    chk(ovr_flag == 0, "R7", ovr_flag, 0);
    pulse_clr(3'b010);
    chk(pause_flag == 0 && cmp_flag == 1, "R8", int'({pause_flag, cmp_flag}), 1);
    irq_en = 1'b0;
    @(negedge clk);
    chk(cmp_irq == 0, "R9", cmp_irq, 0);
    pulse_clr(3'b001);
    chk(cmp_flag == 0, "R8", cmp_flag, 0);

    // R6: table end without terminator
    do_reset();
    for (int i = 0; i < 8; i++) queue_words[i*6 +: 6] = word(15 - i, 0, 0);
    psc_sel = 0;
    ivl_sel = 0;
    nrec = 0;
    wait_tick_then(120);
    chk_run(0, 8, "R6");
    chk(cmp_flag == 1 && ovr_flag == 0, "R6", int'({cmp_flag, ovr_flag}), 2);

    // R5: pause position sweep
    for (int pos = 0; pos < 8; pos++) begin
      do_reset();
      for (int i = 0; i < 8; i++) queue_words[i*6 +: 6] = word(i, i == pos, 0);
      psc_sel = 0;
      ivl_sel = 0;
      nrec = 0;
      wait_tick_then(120);
      chk_run(0, pos + 1, "R5");
      chk(pause_flag == 1, "R5", pause_flag, 1);
      wait_tick_then(120);
      chk_run(pos + 1, 7 - pos, "R5");
      chk(cmp_flag == 1, "R6", cmp_flag, 1);
    end

    // R6: end-of-queue position sweep
    for (int pos = 0; pos < 8; pos++) begin
      do_reset();
      for (int i = 0; i < 8; i++) queue_words[i*6 +: 6] = word(i + 1, 0, i == pos);
      psc_sel = 0;
      ivl_sel = 0;
      nrec = 0;
      wait_tick_then(120);
      chk_run(0, pos, "R6");
      chk(cmp_flag == 1, "R6", cmp_flag, 1);
    end

    // R7: slow converter, tick arrives mid-conversion
    do_reset();
    for (int i = 0; i < 8; i++) queue_words[i*6 +: 6] = word(i, 0, i == 2);
    lat = 400;
    psc_sel = 0;
    ivl_sel = 0;
    nrec = 0;
    wait_tick_then(50);
    chk(ovr_flag == 0, "R7", ovr_flag, 0);
    wait_tick_then(2);
    chk(ovr_flag == 1, "R7", ovr_flag, 1);
    ivl_sel = 4'd15;
    pulse_clr(3'b100);
    chk(ovr_flag == 0, "R8", ovr_flag, 0);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule